// File: doc/BRIEF.md
# Three-Phase Dead-Band Inserter for Bridge Drive

This block sits between a compare unit and the gate drivers of a three-leg bridge. For each phase it receives one signal that marks the active slot of the PWM cycle. From it the block produces a leading output and a trailing output. The trailing output goes active as soon as the slot opens. The leading output follows only after a programmable dead time. When the slot closes, the leading output drops at once and the trailing output holds for the dead time. Pin polarity is applied further downstream, so here "active" always means logic 1.

A single 16-bit configuration word is loaded through a write strobe. It sets an 8-bit dead-time count, an enable for each phase, and a prescaler code. The prescaler slows the clock that advances the dead-time counters. A separate underflow input marks a slot closure that comes from the symmetric time base turning around. Such a closure drops both outputs together, with no dead time.

Each phase runs a four-state machine:
- `PH_IDLE`: both outputs inactive.
- `PH_LEAD`: the trailing output is active while the leading output waits for the count.
- `PH_FULL`: both outputs active.
- `PH_TRAIL`: the leading output has dropped and the trailing output waits for the count.

Transitions:
- Open: `PH_IDLE`→`PH_LEAD`, or →`PH_FULL` when the phase is bypassed.
- Arm: `PH_LEAD`→`PH_FULL` on expiry.
- Close: `PH_FULL`/`PH_LEAD`→`PH_TRAIL`.
- Reopen: `PH_TRAIL`→`PH_LEAD`.
- Release: `PH_TRAIL`→`PH_IDLE` on expiry.
- Drop: any state→`PH_IDLE` on an underflow closure or a bypassed closure.

Top module: `dbg_deadband_top`

## Requirements
- R1: While reset is held and after it is released with no slot active, all six outputs are 0 and every dead-time counter is cleared.
- R2: When a phase's slot input rises with that phase enabled, its trailing output is 1 and its leading output is 0 after the sampling edge. The counter is cleared on that edge and advances once per prescaler tick. The leading output becomes 1 on the edge after the one at which the count equals the dead-time value, provided the slot is still active. With divide-by-1 and dead time d, the leading output rises d+1 edges after the trailing output.
- R3: When a slot falls without an underflow mark and the phase is enabled, the leading output is 0 after the sampling edge. The trailing output stays 1 until the count reaches the dead-time value, with the same timing as R2. The leading output is never 1 while the trailing output is 0.
- R4: When the slot input is 0 and the underflow input is 1 on the same edge, both outputs of every phase are 0 after that edge, whatever state the phase was in.
- R5: A phase whose enable bit is 0 drives both of its outputs equal to the slot input value from the previous edge, with no delay inserted.
- R6: A slot pulse shorter than the dead time never drives the leading output to 1. Likewise a gap shorter than the dead time never drops the trailing output.
- R7: A new edge on the slot input while a dead-time count is running clears the counter. The pending delayed transition is cancelled, and timing restarts from the new edge.
- R8: Configuration word layout: bits 15:8 hold the dead-time value. Bits 5, 6 and 7 enable phases 0, 1 and 2. Bits 4:3 hold the prescaler code. Bits 2:0 are ignored. The word takes effect on the edge after the write strobe.
- R9: Prescaler codes 00, 01, 10 and 11 divide by 1, 2, 4 and 8. A free-running 3-bit cycle counter, cleared by reset, gives a tick on every cycle whose low k bits are all 1 (k = code).
- R10: The three phases operate independently, sharing only the configuration word and the prescaler tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word (layout in R8) |
| slot_act | input | 3 | Active-slot signal, one bit per phase |
| uf_evt | input | 1 | Marks a slot closure caused by time-base underflow |
| drv_lead | output | 3 | Leading (delayed-on, immediate-off) output per phase |
| drv_trail | output | 3 | Trailing (immediate-on, delayed-off) output per phase |

## Verification
The bench goes after these corner cases:
- A zero dead time, where an off-by-one counter would either overlap the outputs or add an extra cycle.
- Pulses and gaps shorter than the dead time, where a counter that is not restarted would let the leading output rise inside a short pulse and overlap the pair.
- An underflow closure, where a design that ignores the mark would leave the trailing output high for the dead time.
- A bypassed phase, where a delayed path would show up as lag.
- Every prescaler code, where a wrong tick phase shifts the delayed edge by whole cycles.

Each of these is compared cycle by cycle against a behavioural model.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    localparam int NPH      = 3;
    localparam int DT_W     = 8;
    localparam int PSC_W    = 2;
    localparam int CFG_W    = 16;
    localparam int DT_LSB   = 8;
    localparam int EN_LSB   = 5;
    localparam int PSC_LSB  = 3;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_FULL  = 2'd2,
        PH_TRAIL = 2'd3
    } ph_state_e;

    typedef struct packed {
        logic [DT_W-1:0]  dt;
        logic [NPH-1:0]   en;
        logic [PSC_W-1:0] psc;
    } dbg_cfg_t;
endpackage

// File: rtl/dbg_cfg_reg.sv
module dbg_cfg_reg
    import dbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output dbg_cfg_t         cfg
);
    logic cfg_unused_bits;
    assign cfg_unused_bits = ^cfg_wdata[PSC_LSB-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_we) begin
            cfg.dt  <= cfg_wdata[DT_LSB +: DT_W];
            cfg.en  <= cfg_wdata[EN_LSB +: NPH];
            cfg.psc <= cfg_wdata[PSC_LSB +: PSC_W];
        end
    end
endmodule

// File: rtl/dbg_tick_gen.sv
module dbg_tick_gen #(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam int CW = (1 << PSC_W) - 1;

    logic [CW-1:0] pre;
    logic [CW-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre <= '0;
        else        pre <= pre + 1'b1;
    end

    always_comb begin
        for (int i = 0; i < CW; i++) begin
            mask[i] = (i < int'(psc));
        end
        tick = &(pre | ~mask);
    end

    // R9: divide-by-1 ticks every cycle
    assert_div1_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (psc == '0) |-> tick);
endmodule

// File: rtl/dbg_phase_fsm.sv
module dbg_phase_fsm
    import dbg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] dt,
    input  logic             en,
    input  logic             act,
    input  logic             uf,
    output logic             out_lead,
    output logic             out_trail
);
    ph_state_e        state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             clr;
    logic             expired;
    logic             armed;

    assign expired = (cnt >= dt);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= nxt;
    end

    // dead-time counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if ((state == PH_LEAD || state == PH_TRAIL) && tick && cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // next state
    always_comb begin
        nxt = state;
        clr = 1'b0;
        unique case (state)
            PH_IDLE: begin
                if (act) begin
                    nxt = en ? PH_LEAD : PH_FULL;
                    clr = 1'b1;
                end
            end
            PH_LEAD: begin
                if (!act) begin
                    if (uf || !en) begin
                        nxt = PH_IDLE;
                    end else begin
                        nxt = PH_TRAIL;
                        clr = 1'b1;
                    end
                end else if (!en || expired) begin
                    nxt = PH_FULL;
                end
            end
            PH_FULL: begin
                if (!act) begin
                    if (uf || !en) begin
                        nxt = PH_IDLE;
                    end else begin
                        nxt = PH_TRAIL;
                        clr = 1'b1;
                    end
                end
            end
            PH_TRAIL: begin
                if (act) begin
                    if (!en) begin
                        nxt = PH_FULL;
                    end else begin
                        nxt = PH_LEAD;
                        clr = 1'b1;
                    end
                end else if (uf || !en || expired) begin
                    nxt = PH_IDLE;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        out_lead  = 1'b0;
        out_trail = 1'b0;
        unique case (state)
            PH_IDLE:  begin out_lead = 1'b0; out_trail = 1'b0; end
            PH_LEAD:  begin out_lead = 1'b0; out_trail = 1'b1; end
            PH_FULL:  begin out_lead = 1'b1; out_trail = 1'b1; end
            PH_TRAIL: begin out_lead = 1'b0; out_trail = 1'b1; end
        endcase
    end

    assert_open_edge_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (en && $rose(act)) |=> (out_trail && !out_lead));

    assert_close_edge_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (en && !uf && $fell(act)) |=> (out_trail && !out_lead));

    assert_lead_needs_trail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_lead |-> out_trail);

    assert_underflow_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && uf) |=> (!out_lead && !out_trail));

    assert_bypass_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (out_lead == $past(act) && out_trail == $past(act)));
endmodule

// File: rtl/dbg_deadband_top.sv
module dbg_deadband_top
    import dbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [NPH-1:0]   slot_act,
    input  logic             uf_evt,
    output logic [NPH-1:0]   drv_lead,
    output logic [NPH-1:0]   drv_trail
);
    dbg_cfg_t cfg;
    logic     tick;

    dbg_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    dbg_tick_gen #(.PSC_W(PSC_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .psc   (cfg.psc),
        .tick  (tick)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        dbg_phase_fsm #(.CNT_W(DT_W)) u_ph (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .dt        (cfg.dt),
            .en        (cfg.en[p]),
            .act       (slot_act[p]),
            .uf        (uf_evt),
            .out_lead  (drv_lead[p]),
            .out_trail (drv_trail[p])
        );
    end

    // R1: outputs idle while reset is held
    always_comb begin
        if (!rst_n) assert_reset_idle_R1: assert (drv_lead == '0 && drv_trail == '0);
    end
endmodule

// File: tb/dbg_deadband_top_tb.sv
module dbg_deadband_top_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [15:0] cfg_wdata;
    logic [2:0]  slot_act;
    logic        uf_evt;
    logic [2:0]  drv_lead, drv_trail;

    always #2 clk = ~clk;

    dbg_deadband_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .slot_act(slot_act), .uf_evt(uf_evt), .drv_lead(drv_lead), .drv_trail(drv_trail)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string tag = "R1";

    // behavioural reference: mode 0 off, 1 waiting-to-arm, 2 both on, 3 waiting-to-release
    int       m_mode [3];
    int       m_cnt  [3];
    int       m_pre;
    int       m_dt;
    logic [2:0] m_en;
    int       m_psc;

    task automatic chk(input bit ok, input string req, input string what, input int a, input int e);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, a, e, $time);
        end
    endtask

    always @(posedge clk) begin
        int  div;
        bit  tk;
        int  nm;
        bit  a, en, clear, timed_out;
        if (!rst_n) begin
            for (int p = 0; p < 3; p++) begin m_mode[p] = 0; m_cnt[p] = 0; end
            m_pre = 0; m_dt = 0; m_en = 3'b000; m_psc = 0;
        end else begin
            div = 1 << m_psc;
            tk  = ((m_pre % div) == div - 1);
            for (int p = 0; p < 3; p++) begin
                a = slot_act[p]; en = m_en[p]; clear = 0; nm = m_mode[p];
                timed_out = (m_cnt[p] >= m_dt);
                if (nm == 0 && a) begin
                    nm = en ? 1 : 2; clear = 1;
                end else if ((nm == 1 || nm == 2) && !a) begin
                    if (uf_evt || !en) nm = 0;
                    else begin nm = 3; clear = 1; end
                end else if (nm == 1 && a && (!en || timed_out)) begin
                    nm = 2;
                end else if (nm == 3 && a) begin
                    if (!en) nm = 2; else begin nm = 1; clear = 1; end
                end else if (nm == 3 && !a && (uf_evt || !en || timed_out)) begin
                    nm = 0;
                end
                if (clear) m_cnt[p] = 0;
                else if ((m_mode[p] == 1 || m_mode[p] == 3) && tk && m_cnt[p] < 255) m_cnt[p]++;
                m_mode[p] = nm;
            end
            m_pre = (m_pre + 1) % 8;
            if (cfg_we) begin
                m_dt  = cfg_wdata[15:8];
                m_en  = cfg_wdata[7:5];
                m_psc = cfg_wdata[4:3];
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int p = 0; p < 3; p++) begin
                chk(drv_lead[p] == (m_mode[p] == 2), tag, $sformatf("model lead[%0d]", p),
                    drv_lead[p], (m_mode[p] == 2));
                chk(drv_trail[p] == (m_mode[p] != 0), tag, $sformatf("model trail[%0d]", p),
                    drv_trail[p], (m_mode[p] != 0));
            end
        end
    end

    task automatic wcfg(input int dt, input logic [2:0] en, input int psc);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {dt[7:0], en, psc[1:0], 3'b101};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // returns number of negedges until the given output of phase p equals val
    task automatic wait_out(input int p, input bit lead, input bit val, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (((lead ? drv_lead[p] : drv_trail[p]) != val) && k < 100);
    endtask

    initial begin
        int k;
        int max_lead;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; slot_act = '0; uf_evt = 1'b0;
        idle(4);
        chk(drv_lead == 3'b000 && drv_trail == 3'b000, "R1", "outputs in reset",
            {drv_lead, drv_trail}, 0);
        rst_n = 1'b1;
        idle(3);
        chk(drv_lead == 3'b000 && drv_trail == 3'b000, "R1", "outputs after reset",
            {drv_lead, drv_trail}, 0);

        // R8/R2: dead time 3, all phases enabled, divide by 1
        tag = "R8";
        wcfg(3, 3'b111, 0);
        tag = "R2";
        slot_act[0] = 1'b1;
        @(negedge clk);
        chk(drv_trail[0] == 1'b1 && drv_lead[0] == 1'b0, "R2", "trail at once",
            {drv_lead[0], drv_trail[0]}, 1);
        wait_out(0, 1'b1, 1'b1, k);
        chk(k == 4, "R2", "lead rise delay dt=3", k + 1, 5);
        idle(3);
        tag = "R3";
        slot_act[0] = 1'b0;
        @(negedge clk);
        chk(drv_lead[0] == 1'b0 && drv_trail[0] == 1'b1, "R3", "lead drops at once",
            {drv_lead[0], drv_trail[0]}, 1);
        wait_out(0, 1'b0, 1'b0, k);
        chk(k == 4, "R3", "trail fall delay dt=3", k + 1, 5);
        idle(3);

        // R2: zero dead time
        tag = "R2";
        wcfg(0, 3'b111, 0);
        slot_act[1] = 1'b1;
        @(negedge clk);
        wait_out(1, 1'b1, 1'b1, k);
        chk(k == 1, "R2", "lead rise delay dt=0", k + 1, 2);
        idle(2);
        slot_act[1] = 1'b0;
        idle(4);

        // R4: underflow closure
        tag = "R4";
        wcfg(5, 3'b111, 0);
        slot_act = 3'b111;
        idle(10);
        slot_act = 3'b000; uf_evt = 1'b1;
        @(negedge clk);
        uf_evt = 1'b0;
        chk(drv_lead == 3'b000 && drv_trail == 3'b000, "R4", "underflow drops all",
            {drv_lead, drv_trail}, 0);
        idle(3);

        // R5: phase 0 bypassed
        tag = "R5";
        wcfg(6, 3'b110, 0);
        slot_act[0] = 1'b1;
        @(negedge clk);
        chk(drv_lead[0] == 1'b1 && drv_trail[0] == 1'b1, "R5", "bypass rise",
            {drv_lead[0], drv_trail[0]}, 3);
        slot_act[0] = 1'b0;
        @(negedge clk);
        chk(drv_lead[0] == 1'b0 && drv_trail[0] == 1'b0, "R5", "bypass fall",
            {drv_lead[0], drv_trail[0]}, 0);
        idle(2);

        // R6: short pulse under long dead time
        tag = "R6";
        wcfg(10, 3'b111, 0);
        max_lead = 0;
        slot_act[2] = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (drv_lead[2]) max_lead = 1;
        end
        slot_act[2] = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (drv_lead[2]) max_lead = 1;
        end
        chk(max_lead == 0, "R6", "lead never on for short pulse", max_lead, 0);

        // R7: retrigger while counting
        tag = "R7";
        wcfg(6, 3'b111, 0);
        slot_act[1] = 1'b1;
        idle(3);
        slot_act[1] = 1'b0;
        idle(2);
        slot_act[1] = 1'b1;
        @(negedge clk);
        chk(drv_trail[1] == 1'b1 && drv_lead[1] == 1'b0, "R7", "after reopen",
            {drv_lead[1], drv_trail[1]}, 1);
        wait_out(1, 1'b1, 1'b1, k);
        chk(k == 7, "R7", "lead delay restarts", k + 1, 8);
        slot_act[1] = 1'b0;
        idle(10);

        // R9: all prescaler codes
        tag = "R9";
        for (int c = 1; c < 4; c++) begin
            wcfg(2, 3'b111, c);
            idle(c);
            slot_act[0] = 1'b1;
            @(negedge clk);
            wait_out(0, 1'b1, 1'b1, k);
            k = k + 1;
            chk(k >= 2 * (1 << c) - (1 << c) + 2 && k <= 3 * (1 << c) + 1, "R9",
                $sformatf("lead delay code %0d", c), k, 2 * (1 << c) + 1);
            slot_act[0] = 1'b0;
            idle(30);
        end

        // R10: overlapping independent activity
        tag = "R10";
        wcfg(4, 3'b101, 0);
        slot_act = 3'b001;
        idle(2);
        slot_act = 3'b011;
        idle(3);
        slot_act = 3'b110;
        idle(7);
        slot_act = 3'b100;
        idle(2);
        slot_act = 3'b000;
        idle(12);
        chk(drv_lead == 3'b000 && drv_trail == 3'b000, "R10", "all idle at end",
            {drv_lead, drv_trail}, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog tag=%s actual=hung expected=finished", tag);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule